// File: doc/BRIEF.md
# Two-Channel Light Integration Sequencer

This block paces repeated integration periods for a pair of light-measurement channels. Each channel's converter front end is modelled as a count increment offered once per step tick. The sequencer adds that increment into a per-channel accumulator and clamps the sum at a full-scale ceiling that depends on the period length. When a period ends, it copies both accumulators into the result registers in the same clock. A new period then begins with no gap.

The period length comes from an 8-bit setting written in two's-complement form, so the number of steps is 256 minus the setting. A setting of zero switches the block into host-timed manual mode. In that mode integration runs from a start pulse to a stop pulse, and a fine-resolution counter records how long the run lasted. Integration needs both the power and the enable control. The block can also be told to freeze while an interrupt is pending. Two parameterized prescalers derive the step tick and the fine tick from the system clock.

Top module: `light_integ_seq`

## Requirements
- R1: In timed mode (setting `cfg_steps` not zero), a period lasts 256 − `cfg_steps` step ticks. 0xFF gives 1 step and 0x01 gives 255 steps.
- R2: `cfg_steps` = 0 selects manual mode. A `man_start` pulse begins a run, and the matching `man_stop` pulse ends it and captures the results. A `man_stop` with no run in progress leaves the results and `res_valid` unchanged. In manual mode the result counts the step ticks that fall inside the run.
- R3: `man_ticks` is cleared by `man_start` and then counts fine ticks while a manual run is active. It holds its value after the stop and saturates at 65535 instead of wrapping.
- R4: At the end of a period, `res0` and `res1` load in the same clock. The next period starts at once, so the following update comes exactly one period later.
- R5: Integration advances only while both `pwr_on` and `conv_en` are high. `res_valid` rises when the first period completes.
- R6: Each accumulator adds its increment on every step tick and clamps at full scale. Full scale is min(1024 × steps − 1, 65535) in timed mode and 65535 in manual mode. One step clamps at 1023 and 37 steps clamp at 37887.
- R7: When `halt_on_irq` is high and `irq_active` is asserted, integration freezes. Clearing `irq_active` alone does not restart it. It restarts only after `conv_en` has been low while `irq_active` was low, and `conv_en` is then set again.
- R8: Lowering `conv_en` aborts the period in progress, keeps the previous results and clears `res_valid` on the next clock.
- R9: A step tick occurs every `STEP_DIV` clocks of enabled time. After `conv_en` is driven high in timed mode, `res_valid` becomes visible exactly steps × `STEP_DIV` + 1 rising edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_steps | input | 8 | Period setting, two's complement of the step count; 0 selects manual mode |
| pwr_on | input | 1 | Power control; must be high for integration |
| conv_en | input | 1 | Conversion enable; low aborts and clears valid |
| man_start | input | 1 | One-clock pulse that starts a manual run |
| man_stop | input | 1 | One-clock pulse that ends a manual run |
| halt_on_irq | input | 1 | Freeze integration while an interrupt is pending |
| irq_active | input | 1 | Live interrupt state |
| ch0_inc | input | INC_W | Channel 0 count increment per step tick |
| ch1_inc | input | INC_W | Channel 1 count increment per step tick |
| res0 | output | 16 | Channel 0 result |
| res1 | output | 16 | Channel 1 result |
| res_valid | output | 1 | At least one period has completed since enabling |
| man_ticks | output | 16 | Fine-tick duration of the latest manual run |

## Verification
A step counter that is off by one shows at the ports as `res_valid` rising one `STEP_DIV` early or late, and as results that differ by one increment. Both appear on the very first period after enabling. A stuck halt flag or a missing abort shows as results that stop changing, or that go on changing, within one period of the control edge. A wrong clamp shows as a result above the full-scale value at the first saturating capture. A wrapping duration counter shows as a small `man_ticks` value after a long manual run.

// File: rtl/integ_pkg.sv
package integ_pkg;
  localparam int NCH   = 2;
  localparam int RES_W = 16;

  // Ceiling for a period: min(1024*steps-1, 65535); setting 0 (manual) -> 65535
  function automatic logic [RES_W-1:0] full_scale(input logic [7:0] setting);
    logic [8:0]  steps;
    logic [18:0] span;
    steps = 9'd256 - {1'b0, setting};
    span  = {steps, 10'd0} - 19'd1;
    if (span > 19'h0FFFF) return {RES_W{1'b1}};
    return span[RES_W-1:0];
  endfunction
endpackage

// File: rtl/tick_div.sv
module tick_div #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = $clog2(DIV + 1);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      tick  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      tick  <= 1'b0;
    end
  end
endmodule

// File: rtl/chan_acc.sv
module chan_acc #(
  parameter int DW    = 16,
  parameter int INC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             add,
  input  logic [INC_W-1:0] inc,
  input  logic [DW-1:0]    limit,
  output logic [DW-1:0]    res_val
);
  logic [DW-1:0] acc_q;
  logic [DW:0]   sum;
  logic [DW-1:0] clamped;

  always_comb begin
    sum     = {1'b0, acc_q} + {{(DW + 1 - INC_W){1'b0}}, inc};
    clamped = (sum > {1'b0, limit}) ? limit : sum[DW-1:0];
    res_val = add ? clamped : acc_q;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)  acc_q <= '0;
    else if (add)    acc_q <= clamped;
  end
endmodule

// File: rtl/integ_ctrl.sv
module integ_ctrl #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [7:0]    cfg_steps,
  input  logic          pwr_on,
  input  logic          conv_en,
  input  logic          man_start,
  input  logic          man_stop,
  input  logic          halt_on_irq,
  input  logic          irq_active,
  input  logic          step_tick,
  input  logic          fine_tick,
  output logic          step_run,
  output logic          fine_run,
  output logic          acc_add,
  output logic          acc_clr,
  output logic          capture,
  output logic          valid_q,
  output logic          halted_q,
  output logic [TW-1:0] man_ticks_q
);
  logic       manual, en_ok, run, last, timed_end, man_begin, man_end;
  logic       man_active_q;
  logic [7:0] step_cnt_q;

  always_comb begin
    manual    = (cfg_steps == 8'd0);
    en_ok     = pwr_on && conv_en;
    run       = en_ok && !halted_q;
    step_run  = run && (!manual || man_active_q);
    fine_run  = run && manual && man_active_q;
    acc_add   = step_tick && step_run;
    last      = (step_cnt_q >= ~cfg_steps);
    timed_end = acc_add && !manual && last;
    man_begin = run && manual && man_start && !man_active_q;
    man_end   = run && manual && man_stop && man_active_q;
    capture   = timed_end || man_end;
    acc_clr   = !run || capture || man_begin || (manual && !man_active_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_cnt_q   <= '0;
      man_active_q <= 1'b0;
      valid_q      <= 1'b0;
      halted_q     <= 1'b0;
      man_ticks_q  <= '0;
    end else begin
      if (!run || manual)  step_cnt_q <= '0;
      else if (acc_add)    step_cnt_q <= last ? 8'd0 : step_cnt_q + 8'd1;

      if (!run || !manual) man_active_q <= 1'b0;
      else if (man_begin)  man_active_q <= 1'b1;
      else if (man_end)    man_active_q <= 1'b0;

      if (!en_ok)          valid_q <= 1'b0;
      else if (capture)    valid_q <= 1'b1;

      if (!conv_en && !irq_active)                   halted_q <= 1'b0;
      else if (en_ok && halt_on_irq && irq_active)   halted_q <= 1'b1;

      if (man_begin)
        man_ticks_q <= '0;
      else if (fine_tick && fine_run && man_ticks_q != {TW{1'b1}})
        man_ticks_q <= man_ticks_q + 1'b1;
    end
  end
endmodule

// File: rtl/light_integ_seq.sv
module light_integ_seq
  import integ_pkg::*;
#(
  parameter int STEP_DIV = 337500,
  parameter int FINE_DIV = 1363,
  parameter int INC_W    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       cfg_steps,
  input  logic             pwr_on,
  input  logic             conv_en,
  input  logic             man_start,
  input  logic             man_stop,
  input  logic             halt_on_irq,
  input  logic             irq_active,
  input  logic [INC_W-1:0] ch0_inc,
  input  logic [INC_W-1:0] ch1_inc,
  output logic [15:0]      res0,
  output logic [15:0]      res1,
  output logic             res_valid,
  output logic [15:0]      man_ticks
);
  logic step_run, fine_run, step_tick, fine_tick;
  logic acc_add, acc_clr, capture, halt_w;
  logic [RES_W-1:0] limit;
  logic [INC_W-1:0] inc_a [NCH];
  logic [RES_W-1:0] val_a [NCH];
  logic [RES_W-1:0] res_q [NCH];

  assign limit    = full_scale(cfg_steps);
  assign inc_a[0] = ch0_inc;
  assign inc_a[1] = ch1_inc;

  tick_div #(.DIV(STEP_DIV)) u_step_div (
    .clk(clk), .rst(rst), .en(step_run), .tick(step_tick));

  tick_div #(.DIV(FINE_DIV)) u_fine_div (
    .clk(clk), .rst(rst), .en(fine_run), .tick(fine_tick));

  integ_ctrl #(.TW(16)) u_ctrl (
    .clk(clk), .rst(rst), .cfg_steps(cfg_steps), .pwr_on(pwr_on),
    .conv_en(conv_en), .man_start(man_start), .man_stop(man_stop),
    .halt_on_irq(halt_on_irq), .irq_active(irq_active),
    .step_tick(step_tick), .fine_tick(fine_tick),
    .step_run(step_run), .fine_run(fine_run), .acc_add(acc_add),
    .acc_clr(acc_clr), .capture(capture), .valid_q(res_valid),
    .halted_q(halt_w), .man_ticks_q(man_ticks));

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    chan_acc #(.DW(RES_W), .INC_W(INC_W)) u_acc (
      .clk(clk), .rst(rst), .clr(acc_clr), .add(acc_add),
      .inc(inc_a[g]), .limit(limit), .res_val(val_a[g]));

    always_ff @(posedge clk) begin
      if (rst)          res_q[g] <= '0;
      else if (capture) res_q[g] <= val_a[g];
    end
  end

  assign res0 = res_q[0];
  assign res1 = res_q[1];
endmodule

// File: rtl/light_integ_seq_chk.sv
module light_integ_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic        pwr_on,
  input logic        conv_en,
  input logic        man_start,
  input logic [15:0] res0,
  input logic [15:0] res1,
  input logic        res_valid,
  input logic [15:0] man_ticks,
  input logic        halted
);
  AST_OFF_CLEARS_VALID: assert property (@(posedge clk) disable iff (rst)
    !conv_en |=> !res_valid); // R8

  AST_HOLD_WHEN_UNPOWERED: assert property (@(posedge clk) disable iff (rst)
    (!conv_en || !pwr_on) |=> ($stable(res0) && $stable(res1))); // R5

  AST_TICKS_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (man_ticks == 16'hFFFF && !man_start) |=> man_ticks == 16'hFFFF); // R3

  AST_UPDATE_SETS_VALID: assert property (@(posedge clk) disable iff (rst)
    (!$stable(res0) || !$stable(res1)) |-> res_valid); // R4

  AST_HALT_FREEZES: assert property (@(posedge clk) disable iff (rst)
    halted |=> ($stable(res0) && $stable(res1))); // R7
endmodule

bind light_integ_seq light_integ_seq_chk u_chk (
  .clk(clk), .rst(rst), .pwr_on(pwr_on), .conv_en(conv_en),
  .man_start(man_start), .res0(res0), .res1(res1), .res_valid(res_valid),
  .man_ticks(man_ticks), .halted(halt_w));

// File: tb/light_integ_seq_bench.sv
module light_integ_seq_bench;
  localparam int SD = 8;
  localparam int FD = 1;

  logic        clk = 1'b0, rst = 1'b1;
  logic [7:0]  cfg_steps = 8'hFF;
  logic        pwr_on = 1'b0, conv_en = 1'b0, man_start = 1'b0, man_stop = 1'b0;
  logic        halt_on_irq = 1'b0, irq_active = 1'b0;
  logic [15:0] ch0_inc = '0, ch1_inc = '0;
  logic [15:0] res0, res1, man_ticks;
  logic        res_valid;
  int          n_cmp = 0, n_bad = 0;
  bit          done = 1'b0;

  light_integ_seq #(.STEP_DIV(SD), .FINE_DIV(FD), .INC_W(16)) u_light_integ_seq (
    .clk(clk), .rst(rst), .cfg_steps(cfg_steps), .pwr_on(pwr_on),
    .conv_en(conv_en), .man_start(man_start), .man_stop(man_stop),
    .halt_on_irq(halt_on_irq), .irq_active(irq_active),
    .ch0_inc(ch0_inc), .ch1_inc(ch1_inc), .res0(res0), .res1(res1),
    .res_valid(res_valid), .man_ticks(man_ticks));

  always #4 clk = ~clk;

  function automatic int steps_of(input int s);
    return 256 - s;
  endfunction

  function automatic int ceil_of(input int s);
    int c;
    if (s == 0) return 65535;
    c = steps_of(s) * 1024 - 1;
    return (c > 65535) ? 65535 : c;
  endfunction

  function automatic int expect_res(input int s, input int inc, input int n);
    int t;
    t = inc * n;
    return (t > ceil_of(s)) ? ceil_of(s) : t;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // timed period: first result timing, values, then back-to-back period
  task automatic timed_trial(input int s, input int a0, input int a1,
                             input int b0, input int b1);
    int n, p;
    conv_en = 1'b0;
    idle(2);
    cfg_steps = 8'(s); ch0_inc = 16'(a0); ch1_inc = 16'(a1);
    conv_en = 1'b1;
    p = steps_of(s) * SD;
    idle(p);
    check("R9 valid not early", int'(res_valid), 0);
    idle(1);
    check("R9/R5 valid at first completion", int'(res_valid), 1);
    check("R1/R6 res0", int'(res0), expect_res(s, a0, steps_of(s)));
    check("R4/R6 res1", int'(res1), expect_res(s, a1, steps_of(s)));
    ch0_inc = 16'(b0); ch1_inc = 16'(b1);
    n = p - 1;
    idle(n);
    check("R4 no early update", int'(res0), expect_res(s, a0, steps_of(s)));
    idle(1);
    check("R4 next period res0", int'(res0), expect_res(s, b0, steps_of(s)));
    check("R4 next period res1", int'(res1), expect_res(s, b1, steps_of(s)));
  endtask

  // manual run whose stop lands d edges after the start edge
  task automatic man_run(input int d);
    @(negedge clk); man_start = 1'b1;
    @(negedge clk); man_start = 1'b0;
    idle(d - 1);
    man_stop = 1'b1;
    @(negedge clk); man_stop = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int s, a0, a1, b0, b1, hold0, hold1;
    void'($urandom(32'd7719));
    idle(3);
    rst = 1'b0;
    idle(1);
    check("R5 reset valid", int'(res_valid), 0);
    check("R4 reset res0", int'(res0), 0);
    check("R3 reset man_ticks", int'(man_ticks), 0);

    // R5: enable without power does nothing
    cfg_steps = 8'hFF; ch0_inc = 16'd3; conv_en = 1'b1;
    idle(40);
    check("R5 no power no valid", int'(res_valid), 0);
    check("R5 no power res0", int'(res0), 0);
    pwr_on = 1'b1;
    conv_en = 1'b0;

    // directed periods
    timed_trial(8'hFF, 5, 7, 9, 3);
    timed_trial(8'hFF, 2000, 1500, 1023, 1024); // R6 one step clamps at 1023
    timed_trial(8'hFE, 600, 400, 1100, 30);     // R6 2 steps clamp 2047
    timed_trial(8'hDB, 1100, 900, 1023, 1024);  // R6 37 steps clamp 37887
    timed_trial(8'h01, 300, 250, 1, 257);       // R1 255 steps, R6 65535

    // random periods, R1/R6
    for (int k = 0; k < 8; k++) begin
      s  = int'(8'hC0 | 8'($urandom % 64));
      a0 = int'($urandom % 2100); a1 = int'($urandom % 2100);
      b0 = int'($urandom % 2100); b1 = int'($urandom % 2100);
      timed_trial(s, a0, a1, b0, b1);
    end

    // R8: abort mid period keeps results, clears valid
    hold0 = int'(res0); hold1 = int'(res1);
    idle(5);
    conv_en = 1'b0;
    idle(1);
    check("R8 valid cleared", int'(res_valid), 0);
    idle(30);
    check("R8 res0 kept", int'(res0), hold0);
    check("R8 res1 kept", int'(res1), hold1);

    // R7: halt on interrupt and the restart sequence
    cfg_steps = 8'hFE; ch0_inc = 16'd11; ch1_inc = 16'd13;
    halt_on_irq = 1'b1; conv_en = 1'b1;
    idle(5);
    irq_active = 1'b1;
    idle(60);
    check("R7 halted no valid", int'(res_valid), 0);
    check("R7 halted res0 frozen", int'(res0), hold0);
    irq_active = 1'b0;
    idle(60);
    check("R7 clearing irq alone no restart", int'(res_valid), 0);
    check("R7 res1 still frozen", int'(res1), hold1);
    conv_en = 1'b0;
    idle(2);
    conv_en = 1'b1;
    idle(2 * SD);
    check("R7 restart not early", int'(res_valid), 0);
    idle(1);
    check("R7 resumed valid", int'(res_valid), 1);
    check("R7 resumed res0", int'(res0), 22);
    halt_on_irq = 1'b0;

    // R2: manual mode
    conv_en = 1'b0;
    idle(2);
    cfg_steps = 8'h00; ch0_inc = 16'd100; ch1_inc = 16'd3;
    conv_en = 1'b1;
    hold0 = int'(res0);
    man_stop = 1'b1; @(negedge clk); man_stop = 1'b0;
    idle(3);
    check("R2 stray stop res0", int'(res0), hold0);
    check("R2 stray stop valid", int'(res_valid), 0);

    // R3/R6: long run saturates duration counter and channel
    man_run(66000);
    check("R3 man_ticks saturates", int'(man_ticks), 65535);
    check("R6 manual clamp res0", int'(res0), expect_res(0, 100, (66000 - 1) / SD));
    check("R2 manual res1", int'(res1), expect_res(0, 3, (66000 - 1) / SD));
    check("R2 manual valid", int'(res_valid), 1);

    // R2/R3: short run clears the counter at start
    ch0_inc = 16'd10; ch1_inc = 16'd20;
    man_run(50);
    check("R3 man_ticks short run", int'(man_ticks), (50 - 1) / FD);
    check("R2 short run res0", int'(res0), 10 * ((50 - 1) / SD));
    check("R2 short run res1", int'(res1), 20 * ((50 - 1) / SD));
    idle(20);
    check("R3 man_ticks held", int'(man_ticks), (50 - 1) / FD);
    check("R2 result held after stop", int'(res0), 10 * ((50 - 1) / SD));

    finish_run();
  end
endmodule